// File: doc/BRIEF.md
# Receive Sampling Tap Sweep Engine

This block finds a good receive sampling point for a high-speed memory-card link without software in the loop. On a start request it steps through the safe tap range of the PHY's 6-bit receive delay, programs each tap, and asks an external tuning tester whether a transfer at that delay succeeds. The engine keeps the longest run of consecutive good taps, then programs the middle of that run as the working delay.

Each tap is loaded by placing the value on the tune bus and raising an update request. The request stays high until the PHY reports completion. Because of a receive-path timing defect in the PHY, every load is issued twice back to back. If the PHY does not complete an update within a bounded wait, that tap counts as bad. The sweep runs only in the two highest-speed bus modes. In every other mode a start finishes at once and changes nothing.

Top module: `rx_tap_sweep`

## Requirements
- R1: A sweep visits taps 0, 1, ... up to TAP_COUNT-1 (default 39) in ascending order. No update request is ever raised with a tune value of TAP_COUNT or above.
- R2: Loading a tap raises `tune_upd_o` twice. The first request falls after the PHY pulses `phy_upd_clr_i`. The line then stays low for one cycle, and the second request is raised. `tune_val_o` does not change while a request is held.
- R3: If a request has been high for TIMEOUT_CYC cycles without a clear, it is dropped. The tap is recorded as failing, with no second request and no tuning test.
- R4: After both loads of a tap complete, `test_start_o` pulses for one cycle, and never while an update is pending. The tap's result is `test_pass_i` in the cycle `test_done_i` is high.
- R5: A failing tap resets the running streak. A passing tap extends it. Only a strictly longer streak replaces the recorded best, so ties keep the earliest window.
- R6: When at least one tap passes, the final tap is the best streak's last tap minus half its length, rounded down. It is loaded with the same double update, appears on `tune_val_o`, and is latched on `final_tap_o` when done pulses.
- R7: If no tap passes, `done_o` and `error_o` pulse together. No final tap is loaded, and `final_tap_o` keeps its previous value.
- R8: Speed mode codes 4 (HS200) and 5 (SDR104) start a sweep. Any other code makes `done_o` pulse in the cycle after start, with no update request, no test and no error.
- R9: `done_o` is a one-cycle pulse, one per accepted start. A start that arrives while a sweep is running is ignored.
- R10: Synchronous active-low reset clears every output to zero and abandons any sweep in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken when idle |
| speed_mode_i | input | 3 | Current bus speed mode code |
| tune_val_o | output | 6 | Tap value presented to the PHY |
| tune_upd_o | output | 1 | Update request to the PHY |
| phy_upd_clr_i | input | 1 | PHY pulse: update applied |
| test_start_o | output | 1 | One-cycle request for a tuning test |
| test_done_i | input | 1 | Tuning test finished |
| test_pass_i | input | 1 | Test result, valid with test_done_i |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Pulses with done when no tap passed |
| final_tap_o | output | 6 | Last centred tap applied |

## Verification
The bench targets the window edges: a passing run that touches tap 0 or tap 39, two equally long runs, and a longer run that comes later. A design that replaced the best run on ties, or took the centre from the start tap, would return a different final tap in these cases. PHY updates that never complete are injected both outside and inside the passing window. If a timed-out tap were treated as good, or still received a second request or a test, the final tap and the counted request edges would both be wrong. The bench also checks the non-tuning modes, the all-fail case, a start issued in the middle of a sweep, and a reset in the middle of a sweep. It watches for a missing error flag, a wrongly rewritten final tap, and an extra done pulse.

// File: rtl/tap_sweep_pkg.sv
// Shared constants and state types for the receive tap sweep engine.
package tap_sweep_pkg;

    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_HS200  = 3'd4;
    localparam logic [MODE_W-1:0] MODE_SDR104 = 3'd5;

    typedef enum logic [2:0] {
        C_IDLE,
        C_WAIT_APPLY,
        C_WAIT_TEST,
        C_STEP,
        C_WAIT_FINAL
    } ctrl_state_t;

    typedef enum logic [1:0] {
        L_IDLE,
        L_ISSUE,
        L_GAP
    } load_state_t;

endpackage

// File: rtl/tap_loader.sv
// Loads one tap into the PHY by issuing the update request twice.
// Assumes the PHY acknowledges each request with a one-cycle clear pulse.
// A request left unacknowledged for TIMEOUT_CYC cycles aborts the load with ok_o=0.
module tap_loader
    import tap_sweep_pkg::*;
#(
    parameter int TAP_W       = 6,
    parameter int TIMEOUT_CYC = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [TAP_W-1:0] tap_i,
    input  logic             clr_i,
    output logic [TAP_W-1:0] tune_val_o,
    output logic             tune_upd_o,
    output logic             finish_o,
    output logic             ok_o
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    load_state_t       st_q;
    logic              second_q;
    logic [CNT_W-1:0]  wait_q;

    // Double-issue sequencer with a bounded wait for each clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= L_IDLE;
            second_q   <= 1'b0;
            wait_q     <= '0;
            tune_val_o <= '0;
            tune_upd_o <= 1'b0;
            finish_o   <= 1'b0;
            ok_o       <= 1'b0;
        end else begin
            finish_o <= 1'b0;
            case (st_q)
                L_IDLE: begin
                    if (go_i) begin
                        tune_val_o <= tap_i;
                        tune_upd_o <= 1'b1;
                        second_q   <= 1'b0;
                        wait_q     <= '0;
                        st_q       <= L_ISSUE;
                    end
                end
                L_ISSUE: begin
                    if (clr_i) begin
                        tune_upd_o <= 1'b0;
                        if (second_q) begin
                            finish_o <= 1'b1;
                            ok_o     <= 1'b1;
                            st_q     <= L_IDLE;
                        end else begin
                            st_q <= L_GAP;
                        end
                    end else if (wait_q == CNT_LAST) begin
                        tune_upd_o <= 1'b0;
                        finish_o   <= 1'b1;
                        ok_o       <= 1'b0;
                        st_q       <= L_IDLE;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                L_GAP: begin
                    tune_upd_o <= 1'b1;
                    second_q   <= 1'b1;
                    wait_q     <= '0;
                    st_q       <= L_ISSUE;
                end
                default: st_q <= L_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/streak_tracker.sv
// Keeps the running streak of passing taps and the longest one seen so far.
// Only a strictly longer streak replaces the record, so the earliest window wins a tie.
module streak_tracker #(
    parameter int TAP_W = 6,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             rec_i,
    input  logic             pass_i,
    input  logic [TAP_W-1:0] tap_i,
    output logic [LEN_W-1:0] best_len_o,
    output logic [TAP_W-1:0] best_end_o
);
    logic [LEN_W-1:0] cur_q;
    logic [LEN_W-1:0] cur_next;

    // Length the running streak would reach on a pass
    always_comb cur_next = cur_q + 1'b1;

    // Streak bookkeeping, one result per record strobe
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cur_q      <= '0;
            best_len_o <= '0;
            best_end_o <= '0;
        end else if (rec_i) begin
            if (pass_i) begin
                cur_q <= cur_next;
                if (cur_next > best_len_o) begin
                    best_len_o <= cur_next;
                    best_end_o <= tap_i;
                end
            end else begin
                cur_q <= '0;
            end
        end
    end

endmodule

// File: rtl/sweep_ctrl.sv
// Sequences the sweep: mode gating, per-tap load and test, and final centring.
// Assumes test_done_i arrives at some point after each test_start_o pulse.
module sweep_ctrl
    import tap_sweep_pkg::*;
#(
    parameter int TAP_W     = 6,
    parameter int TAP_COUNT = 40,
    parameter int LEN_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] speed_mode_i,
    input  logic              ld_finish_i,
    input  logic              ld_ok_i,
    input  logic              test_done_i,
    input  logic              test_pass_i,
    input  logic [LEN_W-1:0]  best_len_i,
    input  logic [TAP_W-1:0]  best_end_i,
    output logic              ld_go_o,
    output logic [TAP_W-1:0]  ld_tap_o,
    output logic              trk_clear_o,
    output logic              trk_rec_o,
    output logic              trk_pass_o,
    output logic              test_start_o,
    output logic              done_o,
    output logic              error_o,
    output logic [TAP_W-1:0]  final_tap_o
);
    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(TAP_COUNT - 1);

    ctrl_state_t      st_q;
    logic             tunable;
    logic [TAP_W-1:0] centre;

    // Only the two fastest bus modes need a sweep
    always_comb tunable = (speed_mode_i == MODE_HS200) || (speed_mode_i == MODE_SDR104);

    // Centre of the best window: last tap minus half its length
    always_comb centre = best_end_i - TAP_W'(best_len_i >> 1);

    // Tracker strobes line up with the state transition into C_STEP
    always_comb begin
        trk_clear_o = (st_q == C_IDLE) && start_i && tunable;
        trk_rec_o   = ((st_q == C_WAIT_APPLY) && ld_finish_i && !ld_ok_i) ||
                      ((st_q == C_WAIT_TEST) && test_done_i);
        trk_pass_o  = (st_q == C_WAIT_TEST) && test_pass_i;
    end

    // Main sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= C_IDLE;
            ld_go_o      <= 1'b0;
            ld_tap_o     <= '0;
            test_start_o <= 1'b0;
            done_o       <= 1'b0;
            error_o      <= 1'b0;
            final_tap_o  <= '0;
        end else begin
            ld_go_o      <= 1'b0;
            test_start_o <= 1'b0;
            done_o       <= 1'b0;
            error_o      <= 1'b0;
            case (st_q)
                C_IDLE: begin
                    if (start_i) begin
                        if (tunable) begin
                            ld_tap_o <= '0;
                            ld_go_o  <= 1'b1;
                            st_q     <= C_WAIT_APPLY;
                        end else begin
                            done_o <= 1'b1;
                        end
                    end
                end
                C_WAIT_APPLY: begin
                    if (ld_finish_i) begin
                        if (ld_ok_i) begin
                            test_start_o <= 1'b1;
                            st_q         <= C_WAIT_TEST;
                        end else begin
                            st_q <= C_STEP;
                        end
                    end
                end
                C_WAIT_TEST: begin
                    if (test_done_i) st_q <= C_STEP;
                end
                C_STEP: begin
                    if (ld_tap_o == LAST_TAP) begin
                        if (best_len_i == '0) begin
                            done_o  <= 1'b1;
                            error_o <= 1'b1;
                            st_q    <= C_IDLE;
                        end else begin
                            ld_tap_o <= centre;
                            ld_go_o  <= 1'b1;
                            st_q     <= C_WAIT_FINAL;
                        end
                    end else begin
                        ld_tap_o <= ld_tap_o + 1'b1;
                        ld_go_o  <= 1'b1;
                        st_q     <= C_WAIT_APPLY;
                    end
                end
                C_WAIT_FINAL: begin
                    if (ld_finish_i) begin
                        done_o <= 1'b1;
                        if (ld_ok_i) final_tap_o <= ld_tap_o;
                        else         error_o     <= 1'b1;
                        st_q <= C_IDLE;
                    end
                end
                default: st_q <= C_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rx_tap_sweep.sv
// Top of the receive sampling tap sweep engine.
// Joins the sequencer, the double-issue tap loader and the streak tracker.
module rx_tap_sweep
    import tap_sweep_pkg::*;
#(
    parameter int TAP_W       = 6,
    parameter int TAP_COUNT   = 40,
    parameter int TIMEOUT_CYC = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] speed_mode_i,
    output logic [TAP_W-1:0]  tune_val_o,
    output logic              tune_upd_o,
    input  logic              phy_upd_clr_i,
    output logic              test_start_o,
    input  logic              test_done_i,
    input  logic              test_pass_i,
    output logic              done_o,
    output logic              error_o,
    output logic [TAP_W-1:0]  final_tap_o
);
    localparam int LEN_W = $clog2(TAP_COUNT + 1);

    logic             ld_go;
    logic [TAP_W-1:0] ld_tap;
    logic             ld_finish;
    logic             ld_ok;
    logic             trk_clear;
    logic             trk_rec;
    logic             trk_pass;
    logic [LEN_W-1:0] best_len;
    logic [TAP_W-1:0] best_end;

    sweep_ctrl #(.TAP_W(TAP_W), .TAP_COUNT(TAP_COUNT), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .speed_mode_i(speed_mode_i),
        .ld_finish_i(ld_finish), .ld_ok_i(ld_ok),
        .test_done_i(test_done_i), .test_pass_i(test_pass_i),
        .best_len_i(best_len), .best_end_i(best_end),
        .ld_go_o(ld_go), .ld_tap_o(ld_tap),
        .trk_clear_o(trk_clear), .trk_rec_o(trk_rec), .trk_pass_o(trk_pass),
        .test_start_o(test_start_o), .done_o(done_o), .error_o(error_o),
        .final_tap_o(final_tap_o)
    );

    tap_loader #(.TAP_W(TAP_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_load (
        .clk(clk), .rst_n(rst_n), .go_i(ld_go), .tap_i(ld_tap),
        .clr_i(phy_upd_clr_i), .tune_val_o(tune_val_o), .tune_upd_o(tune_upd_o),
        .finish_o(ld_finish), .ok_o(ld_ok)
    );

    streak_tracker #(.TAP_W(TAP_W), .LEN_W(LEN_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .clear_i(trk_clear), .rec_i(trk_rec),
        .pass_i(trk_pass), .tap_i(ld_tap),
        .best_len_o(best_len), .best_end_o(best_end)
    );

endmodule

// File: rtl/tap_sweep_checker.sv
// Protocol checks on the sweep engine's ports, bound to rx_tap_sweep.
// The request-length window is measured with a counter, so no deep $past is used.
module tap_sweep_checker #(
    parameter int TAP_W       = 6,
    parameter int TAP_COUNT   = 40,
    parameter int TIMEOUT_CYC = 100
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TAP_W-1:0] tune_val_o,
    input logic             tune_upd_o,
    input logic             test_start_o,
    input logic             done_o,
    input logic             error_o
);
    localparam int RUN_W = $clog2(TIMEOUT_CYC + 2);

    logic [RUN_W-1:0] upd_run_q;

    // Length of the current unbroken update request
    always_ff @(posedge clk) begin
        if (!rst_n)          upd_run_q <= '0;
        else if (tune_upd_o) upd_run_q <= upd_run_q + 1'b1;
        else                 upd_run_q <= '0;
    end

    assert_tap_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tune_upd_o |-> (int'(tune_val_o) < TAP_COUNT));

    assert_val_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tune_upd_o && $past(tune_upd_o)) |-> $stable(tune_val_o));

    assert_upd_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(upd_run_q) <= TIMEOUT_CYC);

    assert_test_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        test_start_o |-> !tune_upd_o);

    assert_error_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> done_o);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_test_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        test_start_o |=> !test_start_o);

endmodule

bind rx_tap_sweep tap_sweep_checker #(
    .TAP_W(TAP_W), .TAP_COUNT(TAP_COUNT), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tune_val_o(tune_val_o), .tune_upd_o(tune_upd_o),
    .test_start_o(test_start_o), .done_o(done_o), .error_o(error_o)
);

// File: tb/tb_rx_tap_sweep.sv
module tb_rx_tap_sweep;
    localparam int NT = 40;
    localparam int NV = 9;

    // Vector: {mode[2:0], pass mask[39:0], stuck-update mask[39:0]}
    localparam logic [82:0] VEC [NV] = '{
        {3'd4, 40'h00000FFC00, 40'h0},            // R6 window 10..19
        {3'd5, 40'hFFFFFFFFFF, 40'h0},            // R6 all pass
        {3'd4, 40'h0000F001E0, 40'h0},            // R5 tie, earliest kept
        {3'd5, 40'h0FC000000C, 40'h0},            // R5 later longer window wins
        {3'd4, 40'h8000000000, 40'h0},            // R1 only top tap
        {3'd4, 40'h0000000001, 40'h0},            // R1 only tap 0
        {3'd5, 40'h0000000000, 40'h0},            // R7 none pass
        {3'd4, 40'h00000FFC00, 40'h0002000008},   // R3 stuck outside window
        {3'd5, 40'h00000FFC00, 40'h0000008000}    // R3 stuck splits window
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] speed_mode_i = 3'd0;
    logic [5:0] tune_val_o;
    logic       tune_upd_o;
    logic       phy_upd_clr_i = 1'b0;
    logic       test_start_o;
    logic       test_done_i = 1'b0;
    logic       test_pass_i = 1'b0;
    logic       done_o;
    logic       error_o;
    logic [5:0] final_tap_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic [39:0] cur_mask  = '0;
    logic [39:0] cur_stuck = '0;
    int upd_edges = 0, test_starts = 0, done_cnt = 0, max_tap = 0;
    logic prev_upd = 1'b0;

    rx_tap_sweep dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .speed_mode_i(speed_mode_i),
        .tune_val_o(tune_val_o), .tune_upd_o(tune_upd_o), .phy_upd_clr_i(phy_upd_clr_i),
        .test_start_o(test_start_o), .test_done_i(test_done_i), .test_pass_i(test_pass_i),
        .done_o(done_o), .error_o(error_o), .final_tap_o(final_tap_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // PHY model: clears an update two cycles after it rises, unless the tap is stuck
    initial begin
        int hi;
        hi = 0;
        forever begin
            @(posedge clk); #1;
            if (tune_upd_o) begin
                hi++;
                phy_upd_clr_i = (hi == 2) && !cur_stuck[tune_val_o];
            end else begin
                hi = 0;
                phy_upd_clr_i = 1'b0;
            end
        end
    end

    // Tuning tester model: answers three cycles after a start pulse
    initial begin
        forever begin
            @(posedge clk); #1;
            test_done_i = 1'b0;
            if (test_start_o) begin
                repeat (3) @(posedge clk);
                #1;
                test_pass_i = cur_mask[tune_val_o];
                test_done_i = 1'b1;
            end
        end
    end

    // Port monitor: request edges, test starts, done pulses, highest requested tap
    initial begin
        forever begin
            @(posedge clk); #1;
            if (tune_upd_o && !prev_upd) upd_edges++;
            if (tune_upd_o && int'(tune_val_o) > max_tap) max_tap = int'(tune_val_o);
            prev_upd = tune_upd_o;
            if (test_start_o) test_starts++;
            if (done_o) done_cnt++;
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    function automatic void expect_res(input logic [39:0] eff, output bit err, output int fin);
        int cur, best, last;
        cur = 0; best = 0; last = 0;
        for (int i = 0; i < NT; i++) begin
            if (eff[i]) begin
                cur++;
                if (cur > best) begin best = cur; last = i; end
            end else cur = 0;
        end
        err = (best == 0);
        fin = last - best / 2;
    endfunction

    task automatic clear_counts();
        upd_edges = 0; test_starts = 0; done_cnt = 0; max_tap = 0;
    endtask

    task automatic pulse_start(input logic [2:0] mode);
        @(posedge clk); #1;
        speed_mode_i = mode;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int k = 0; k < 8000 && !seen; k++) begin
            if (done_o) seen = 1;
            else begin @(posedge clk); #1; end
        end
    endtask

    task automatic run_vec(input int idx);
        logic [2:0]  mode;
        logic [39:0] mask, stuck;
        bit err, seen;
        int fin, prev_final, exp_edges, exp_tests;
        {mode, mask, stuck} = VEC[idx];
        cur_mask = mask & ~stuck;
        cur_stuck = stuck;
        expect_res(mask & ~stuck, err, fin);
        prev_final = int'(final_tap_o);
        exp_edges = err ? 0 : 2;
        exp_tests = 0;
        for (int i = 0; i < NT; i++) begin
            exp_edges += stuck[i] ? 1 : 2;
            exp_tests += stuck[i] ? 0 : 1;
        end
        clear_counts();
        pulse_start(mode);
        wait_done(seen);
        check("R9", $sformatf("vec%0d done seen", idx), int'(seen), 1);
        check("R7", $sformatf("vec%0d error", idx), int'(error_o), int'(err));
        check("R6", $sformatf("vec%0d final tap", idx), int'(final_tap_o), err ? prev_final : fin);
        if (!err) check("R6", $sformatf("vec%0d tune value", idx), int'(tune_val_o), fin);
        @(posedge clk); #1;
        check("R2", $sformatf("vec%0d update edges", idx), upd_edges, exp_edges);
        check("R4", $sformatf("vec%0d tests", idx), test_starts, exp_tests);
        check("R1", $sformatf("vec%0d max tap", idx), max_tap, 39);
        check("R9", $sformatf("vec%0d done pulses", idx), done_cnt, 1);
    endtask

    initial begin
        bit seen;
        int keep;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check("R10", "done at reset", int'(done_o), 0);
        check("R10", "upd at reset", int'(tune_upd_o), 0);
        check("R10", "final at reset", int'(final_tap_o), 0);
        check("R10", "tune at reset", int'(tune_val_o), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) run_vec(v);

        // R8 non-tuning modes finish at once with no activity
        for (int m = 0; m < 8; m++) begin
            if (m == 4 || m == 5) continue;
            keep = int'(final_tap_o);
            clear_counts();
            pulse_start(3'(m));
            check("R8", $sformatf("mode %0d done next cycle", m), int'(done_o), 1);
            check("R8", $sformatf("mode %0d no error", m), int'(error_o), 0);
            @(posedge clk); #1;
            check("R9", $sformatf("mode %0d done one cycle", m), int'(done_o), 0);
            repeat (4) @(posedge clk);
            #1;
            check("R8", $sformatf("mode %0d no update", m), upd_edges, 0);
            check("R8", $sformatf("mode %0d final kept", m), int'(final_tap_o), keep);
        end

        // R9 start during a sweep is ignored
        cur_mask = 40'h00000FFC00;
        cur_stuck = '0;
        clear_counts();
        pulse_start(3'd4);
        repeat (60) @(posedge clk);
        pulse_start(3'd0);
        wait_done(seen);
        check("R9", "busy start final", int'(final_tap_o), 14);
        repeat (3) @(posedge clk);
        #1;
        check("R9", "busy start done count", done_cnt, 1);

        // R10 reset mid-sweep
        pulse_start(3'd5);
        repeat (40) @(posedge clk);
        #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R10", "mid reset upd", int'(tune_upd_o), 0);
        check("R10", "mid reset test", int'(test_start_o), 0);
        check("R10", "mid reset final", int'(final_tap_o), 0);
        rst_n = 1'b1;
        clear_counts();
        repeat (20) @(posedge clk);
        #1;
        check("R10", "idle after reset", upd_edges, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule